// File: doc/BRIEF.md
# Field-Selective Vertical Interpolation Controller

This block decides, one video line at a time, whether a vertical interpolation filter should be running or bypassed. It watches active-low horizontal and vertical sync and counts lines. It works out the field parity from where the vertical sync edge falls within a line. At every line start it combines the field parity, a field-select bit, a bypass bit, an external enable pin and a PAL/NTSC flag into one registered enable. A single line in each field and standard is always forced into bypass.

A small demonstration filter sits behind the enable. It holds one line of 8-bit samples. When the enable is on, it outputs the rounded mean of each sample and the sample in the same column of the previous line. When the enable is off, the sample passes through unchanged. The surrounding pipeline is expected to deliver sync and samples in the block's clock domain.

Top module: `vinterp_ctl`

## Requirements
- R1: While reset is held and right after it, `line_num` is 0, `field_even` is 0, `interp_on` is 0 and `pix_out_valid` is 0.
- R2: On a falling edge of `vsync_n`, `line_num` restarts at 1 for an odd field, at 263 for an even NTSC field and at 313 for an even PAL field. Each later falling edge of `hsync_n` adds one, saturating at the counter maximum. If both edges fall in the same cycle, the vertical edge wins.
- R3: A `vsync_n` fall in the same cycle as an `hsync_n` fall, or fewer than ALIGN_WIN (4) clocks after the last one, starts an odd field (`field_even`=0). A later fall starts an even field (`field_even`=1).
- R4: The filter can run only in the selected field: `field_sel`=0 selects the odd field and `field_sel`=1 selects the even field. In the other field `interp_on` is 0.
- R5: `bypass`=1 at a line start makes `interp_on` 0 for that line.
- R6: `filt_en_pin`=0 at a line start makes `interp_on` 0 for that line, whatever the register bits say.
- R7: With the odd field selected, `interp_on` is 0 on line 21 for NTSC (`std_pal`=0) and on line 25 for PAL (`std_pal`=1). With the even field selected, it is 0 on line 285 for NTSC and on line 336 for PAL. The neighbouring lines are not affected.
- R8: `interp_on` is registered. It takes its new value on the clock edge that samples a sync falling edge and holds otherwise, so control inputs changed mid-line have no effect until the next line start.
- R9: With `interp_on`=0, a sample taken with `pix_valid`=1 appears unchanged on `pix_out` one clock later with `pix_out_valid`=1.
- R10: With `interp_on`=1, `pix_out` one clock later is (current + previous-line sample of the same column + 1) >> 1. Columns count from 0 after each `hsync_n` fall. Every valid sample is stored, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| field_sel | input | 1 | 0: run in the odd field, 1: run in the even field |
| bypass | input | 1 | 1 forces the filter off |
| filt_en_pin | input | 1 | External enable, low forces bypass |
| std_pal | input | 1 | 0: NTSC line numbers, 1: PAL line numbers |
| pix_valid | input | 1 | Sample strobe |
| pix_in | input | DW | Input sample |
| line_num | output | LW | Current line number |
| field_even | output | 1 | Parity of the current field |
| interp_on | output | 1 | Per-line filter enable |
| pix_out | output | DW | Filtered or passed sample |
| pix_out_valid | output | 1 | Output sample strobe |

## Verification
The line counter, the field flag and the enable all change on the very edge that samples a sync fall. The bench therefore checks them on the falling clock edge that follows that rising edge, never in the middle of a sync pulse. A filtered sample is due exactly one clock after its `pix_valid` edge, so each sample is checked on the next falling edge before another is driven. Mid-line changes of the control inputs are checked by watching `interp_on` over several idle cycles and then again after the next line start.

// File: rtl/vinterp_ctl.sv
module vinterp_ctl #(
  parameter int DW             = 8,
  parameter int LW             = 10,
  parameter int LINE_LEN       = 16,
  parameter int ALIGN_WIN      = 4,
  parameter int HCW            = 12,
  parameter int NTSC_EVEN_BASE = 263,
  parameter int PAL_EVEN_BASE  = 313,
  parameter int NTSC_ODD_SKIP  = 21,
  parameter int PAL_ODD_SKIP   = 25,
  parameter int NTSC_EVEN_SKIP = 285,
  parameter int PAL_EVEN_SKIP  = 336
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_n,
  input  logic          vsync_n,
  input  logic          field_sel,
  input  logic          bypass,
  input  logic          filt_en_pin,
  input  logic          std_pal,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_in,
  output logic [LW-1:0] line_num,
  output logic          field_even,
  output logic          interp_on,
  output logic [DW-1:0] pix_out,
  output logic          pix_out_valid
);
  localparam int CW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
  localparam logic [CW-1:0] COL_LAST = CW'(LINE_LEN - 1);
  localparam logic [LW-1:0] LINE_MAX = {LW{1'b1}};

  logic hs_q, vs_q;
  logic [HCW-1:0] hcnt;
  logic [CW-1:0] col;
  logic [DW-1:0] lbuf [LINE_LEN];

  wire hs_fall = hs_q & ~hsync_n;
  wire vs_fall = vs_q & ~vsync_n;
  wire line_ev = hs_fall | vs_fall;

  wire even_now = ~hs_fall & (hcnt >= HCW'(ALIGN_WIN));
  wire nxt_even = vs_fall ? even_now : field_even;

  wire [LW-1:0] even_base = std_pal ? LW'(PAL_EVEN_BASE) : LW'(NTSC_EVEN_BASE);
  wire [LW-1:0] nxt_line  = vs_fall ? (even_now ? even_base : LW'(1))
                          : (line_num == LINE_MAX ? line_num : line_num + LW'(1));

  wire [LW-1:0] skip_line = field_sel
                          ? (std_pal ? LW'(PAL_EVEN_SKIP) : LW'(NTSC_EVEN_SKIP))
                          : (std_pal ? LW'(PAL_ODD_SKIP)  : LW'(NTSC_ODD_SKIP));

  wire nxt_on = filt_en_pin & ~bypass & (nxt_even == field_sel) & (nxt_line != skip_line);

  wire [DW:0]   sum = {1'b0, pix_in} + {1'b0, lbuf[col]} + (DW+1)'(1);
  wire [DW-1:0] avg = sum[DW:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
      vs_q <= 1'b1;
      hcnt <= '0;
    end else begin
      hs_q <= hsync_n;
      vs_q <= vsync_n;
      if (hs_fall)
        hcnt <= '0;
      else if (hcnt != {HCW{1'b1}})
        hcnt <= hcnt + HCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_num   <= '0;
      field_even <= 1'b0;
      interp_on  <= 1'b0;
    end else if (line_ev) begin
      line_num   <= nxt_line;
      field_even <= nxt_even;
      interp_on  <= nxt_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      col <= '0;
    else if (hs_fall)
      col <= '0;
    else if (pix_valid && col != COL_LAST)
      col <= col + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (pix_valid)
      lbuf[col] <= pix_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_out       <= '0;
      pix_out_valid <= 1'b0;
    end else begin
      pix_out_valid <= pix_valid;
      if (pix_valid)
        pix_out <= interp_on ? avg : pix_in;
    end
  end
endmodule

// File: rtl/vinterp_ctl_chk.sv
module vinterp_ctl_chk #(
  parameter int DW = 8,
  parameter int LW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          field_sel,
  input logic          bypass,
  input logic          filt_en_pin,
  input logic          std_pal,
  input logic          pix_valid,
  input logic [DW-1:0] pix_in,
  input logic [LW-1:0] line_num,
  input logic          field_even,
  input logic          interp_on,
  input logic [DW-1:0] pix_out,
  input logic          pix_out_valid
);
  logic h_prev, v_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_prev <= 1'b1;
      v_prev <= 1'b1;
    end else begin
      h_prev <= hsync_n;
      v_prev <= vsync_n;
    end
  end
  wire fh = h_prev & ~hsync_n;
  wire fv = v_prev & ~vsync_n;

  a_r8_hold_midline: assert property (@(posedge clk) disable iff (!rst_n)
    (!fh && !fv) |=> $stable(interp_on));

  a_r6_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((fh || fv) && !filt_en_pin) |=> !interp_on);

  a_r5_bypass_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ((fh || fv) && bypass) |=> !interp_on);

  a_r2_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fh && !fv && line_num != {LW{1'b1}}) |=> (line_num == $past(line_num) + LW'(1)));

  a_r3_aligned_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (fh && fv) |=> (!field_even && line_num == LW'(1)));

  a_r4_wrong_field: assert property (@(posedge clk) disable iff (!rst_n)
    (fh && fv && field_sel) |=> !interp_on);

  a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !interp_on && !fh && !fv) |=> (pix_out_valid && pix_out == $past(pix_in)));
endmodule

bind vinterp_ctl vinterp_ctl_chk #(.DW(DW), .LW(LW)) u_chk (.*);

// File: tb/tb_vinterp_ctl.sv
module tb_vinterp_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_n = 1'b1, vsync_n = 1'b1;
  logic field_sel = 1'b0, bypass = 1'b0, filt_en_pin = 1'b1, std_pal = 1'b0;
  logic pix_valid = 1'b0;
  logic [7:0] pix_in = '0;
  logic [9:0] line_num;
  logic field_even, interp_on, pix_out_valid;
  logic [7:0] pix_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vinterp_ctl dut (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .field_sel(field_sel), .bypass(bypass), .filt_en_pin(filt_en_pin),
    .std_pal(std_pal), .pix_valid(pix_valid), .pix_in(pix_in),
    .line_num(line_num), .field_even(field_even), .interp_on(interp_on),
    .pix_out(pix_out), .pix_out_valid(pix_out_valid)
  );

  // {pal, even, sel, byp, pin, line[9:0], exp_on}
  localparam logic [15:0] VEC [0:14] = '{
    {1'b0,1'b0,1'b0,1'b0,1'b1,10'd20, 1'b1},  // R4 odd active
    {1'b0,1'b0,1'b0,1'b0,1'b1,10'd21, 1'b0},  // R7 NTSC odd skip
    {1'b0,1'b0,1'b0,1'b0,1'b1,10'd22, 1'b1},  // R7 neighbour
    {1'b1,1'b0,1'b0,1'b0,1'b1,10'd25, 1'b0},  // R7 PAL odd skip
    {1'b1,1'b0,1'b0,1'b0,1'b1,10'd21, 1'b1},  // R7 NTSC line not skipped in PAL
    {1'b0,1'b1,1'b1,1'b0,1'b1,10'd285,1'b0},  // R7 NTSC even skip
    {1'b0,1'b1,1'b1,1'b0,1'b1,10'd284,1'b1},  // R7 neighbour
    {1'b1,1'b1,1'b1,1'b0,1'b1,10'd336,1'b0},  // R7 PAL even skip
    {1'b1,1'b1,1'b1,1'b0,1'b1,10'd337,1'b1},  // R7 neighbour
    {1'b0,1'b0,1'b1,1'b0,1'b1,10'd10, 1'b0},  // R4 odd field, even selected
    {1'b0,1'b1,1'b0,1'b0,1'b1,10'd270,1'b0},  // R4 even field, odd selected
    {1'b0,1'b0,1'b0,1'b1,1'b1,10'd10, 1'b0},  // R5 bypass bit
    {1'b0,1'b0,1'b0,1'b0,1'b0,10'd10, 1'b0},  // R6 pin low
    {1'b1,1'b1,1'b1,1'b1,1'b1,10'd320,1'b0},  // R5 bypass in PAL even
    {1'b1,1'b1,1'b1,1'b0,1'b1,10'd320,1'b1}   // R4 PAL even active
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hline();
    @(negedge clk) hsync_n = 1'b0;
    @(negedge clk) hsync_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic vstart(input bit even);
    if (!even) begin
      @(negedge clk) begin hsync_n = 1'b0; vsync_n = 1'b0; end
      @(negedge clk) begin hsync_n = 1'b1; vsync_n = 1'b1; end
    end else begin
      @(negedge clk) hsync_n = 1'b0;
      @(negedge clk) hsync_n = 1'b1;
      repeat (10) @(negedge clk);
      vsync_n = 1'b0;
      @(negedge clk) vsync_n = 1'b1;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pix(input logic [7:0] v, input logic [7:0] exp, input string req);
    @(negedge clk) begin pix_valid = 1'b1; pix_in = v; end
    @(negedge clk) begin
      chk(req, int'(pix_out), int'(exp));
      chk(req, int'(pix_out_valid), 1);
      pix_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 line_num", int'(line_num), 0);
    chk("R1 field_even", int'(field_even), 0);
    chk("R1 interp_on", int'(interp_on), 0);
    chk("R1 pix_out_valid", int'(pix_out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 interp_on after release", int'(interp_on), 0);

    foreach (VEC[i]) begin
      automatic logic [15:0] v = VEC[i];
      automatic bit ev = v[14];
      automatic int ln = int'(v[10:1]);
      automatic int st = ev ? (v[15] ? 313 : 263) : 1;
      std_pal = v[15]; field_sel = v[13]; bypass = v[12]; filt_en_pin = v[11];
      vstart(ev);
      chk("R2 field start line", int'(line_num), st);
      chk("R3 field parity", int'(field_even), int'(ev));
      for (int k = st; k < ln; k++) hline();
      chk("R2 line count", int'(line_num), ln);
      chk("R4/R5/R6/R7 enable", int'(interp_on), int'(v[0]));
    end

    // R8: mid-line control change has no effect until next line start
    std_pal = 1'b0; field_sel = 1'b0; bypass = 1'b0; filt_en_pin = 1'b1;
    vstart(1'b0);
    hline();
    chk("R8 active before change", int'(interp_on), 1);
    filt_en_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 pin change mid-line ignored", int'(interp_on), 1);
    bypass = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 bypass change mid-line ignored", int'(interp_on), 1);
    hline();
    chk("R8 applied at next line start", int'(interp_on), 0);
    filt_en_pin = 1'b1;

    // R9 pass-through line, then R10 averaging line
    hline();
    chk("R9 bypassed line", int'(interp_on), 0);
    pix(8'd10,  8'd10,  "R9 pass 10");
    pix(8'd255, 8'd255, "R9 pass 255");
    pix(8'd0,   8'd0,   "R9 pass 0");
    pix(8'd200, 8'd200, "R9 pass 200");
    bypass = 1'b0;
    hline();
    chk("R10 active line", int'(interp_on), 1);
    pix(8'd13,  8'd12,  "R10 avg 10,13 rounds");
    pix(8'd255, 8'd255, "R10 avg 255,255 no overflow");
    pix(8'd1,   8'd1,   "R10 avg 0,1 rounds up");
    pix(8'd100, 8'd150, "R10 avg 200,100");
    hline();
    pix(8'd14,  8'd14,  "R10 avg 13,14 uses stored active line");

    // R2 vertical edge wins over same-cycle horizontal edge after many lines
    vstart(1'b0);
    chk("R2 restart at 1", int'(line_num), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule